// File: doc/BRIEF.md
# Countdown Event Timer

This block is a single one-shot event timer for use as a kernel tick source. Software first sets the run bit in the control register. It then writes a tick count into the count register, and that write starts the countdown. Each cycle in which the tick-enable input is high takes one off the count. When the count lands on zero, an event flag latches and the counter stays at zero until the next load. The interrupt output is a level signal. It is high while the event flag is set and interrupts are enabled.

The run bit acts as a gate for the whole timer. While the run bit is clear:
- count loads are dropped;
- the interrupt-enable and flag-clear bits of a control write do nothing;
- the count stays frozen.

Software usually acknowledges an event by writing the run bit and the clear bit together. That write removes the flag and leaves interrupts off until the next arm sequence.

Top module: `cdtmr_top`

## Requirements
- R1: After reset the count reads 0, the control register reads 0 and `irq` is low.
- R2: The control register sits at address 0x40, with bit 0 = run, bit 1 = interrupt enable and bit 4 = flag clear. Bit 4 always reads back as 0. The count register sits at address 0x44 and reads the live remaining count. Any other address reads 0 and a write to it changes nothing.
- R3: While the run bit is clear, a write to the count register is ignored and the count does not change, even with `tick_en` high.
- R4: A count write while running loads the written value in the next cycle. Any earlier count in progress is discarded and raises no interrupt.
- R5: While running, every clock edge with `tick_en` high decrements a non-zero count by exactly one. With `tick_en` low the count holds.
- R6: A control write with bit 0 = 0 clears both the run bit and interrupt enable. In such a write, bit 1 does not set interrupt enable and bit 4 does not clear the flag.
- R7: A tick that takes the count from 1 to 0 sets the event flag. The count then stays at 0 for later ticks. Loading 0 does not set the flag.
- R8: `irq` equals event flag AND interrupt enable. The flag persists until it is explicitly cleared, so enabling interrupts later still reveals an earlier event.
- R9: A control write with bits 0 and 4 set clears the flag. If an expiry happens in the same cycle, the expiry wins and the flag stays set.
- R10: The count is the full 32 bits wide. Loading 0xFFFFFFFF reads back unchanged, and one tick then gives 0xFFFFFFFE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-down qualifier, one tick per high cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address for both read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq | output | 1 | Level interrupt request |

## Verification
The following are checked by assertions on every cycle:
- the count freezes while stopped and after a write to the count register while stopped;
- a load lands exactly, and a running count steps down by exactly one;
- zero is held;
- the flag is sticky, it is set by expiry and dropped by the acknowledge write;
- a stop write clears both enables.

Some behaviour only shows at the ports across whole scenarios, so the bench scenarios cover it:
- the read-back encoding of the control register;
- that an earlier flag becomes visible on `irq` once interrupts are re-enabled;
- that a reload before expiry suppresses the interrupt;
- the race between the acknowledge write and an expiry in the same cycle.

The bench also sweeps load values 1 to 12 against three tick patterns and compares each cycle with an arithmetic count model.

// File: rtl/cdtmr_pkg.sv
package cdtmr_pkg;

    localparam int RUN_BIT = 0;
    localparam int IEN_BIT = 1;
    localparam int CLR_BIT = 4;

    typedef struct packed {
        logic run;
        logic ien;
        logic flag;
    } ctrl_state_t;

endpackage

// File: rtl/cdtmr_ctrl.sv
module cdtmr_ctrl
    import cdtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic wr_run,
    input  logic wr_ien,
    input  logic wr_clr,
    input  logic expire,
    output logic run,
    output logic ien,
    output logic flag
);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl) begin
            if (wr_run) begin
                st_d.run = 1'b1;
                st_d.ien = wr_ien;
                if (wr_clr) begin
                    st_d.flag = 1'b0;
                end
            end else begin
                st_d.run = 1'b0;
                st_d.ien = 1'b0;
            end
        end
        if (expire) begin
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign run  = st_q.run;
    assign ien  = st_q.ien;
    assign flag = st_q.flag;

    AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && !wr_run) |=> (!run && !ien)); // R6
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wr_run && wr_clr && !expire) |=> !flag); // R9
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag); // R7
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_ctrl && wr_run && wr_clr)) |=> flag); // R8

endmodule

// File: rtl/cdtmr_counter.sv
module cdtmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (load) begin
            st_d.cnt = load_val;
        end else if (run && tick && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - ONE;
            expire   = (st_q.cnt == ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;

    AST_FROZEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> $stable(count)); // R3
    AST_LOAD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (count == $past(load_val))); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !load && (count != '0)) |=> (count == $past(count) - ONE)); // R5
    AST_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((count == '0) && !load) |=> (count == '0)); // R7

endmodule

// File: rtl/cdtmr_top.sv
module cdtmr_top
    import cdtmr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 8,
    parameter int CTRL_ADDR = 'h40,
    parameter int CNT_ADDR  = 'h44
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_ADDR);

    logic              sel_ctrl, sel_cnt;
    logic              wr_ctrl, load;
    logic              run, ien, flag, expire;
    logic [DATA_W-1:0] count;

    assign sel_ctrl = (reg_addr == CTRL_A);
    assign sel_cnt  = (reg_addr == CNT_A);
    assign wr_ctrl  = reg_wr && sel_ctrl;
    assign load     = reg_wr && sel_cnt && run;

    cdtmr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_ctrl (wr_ctrl),
        .wr_run  (reg_wdata[RUN_BIT]),
        .wr_ien  (reg_wdata[IEN_BIT]),
        .wr_clr  (reg_wdata[CLR_BIT]),
        .expire  (expire),
        .run     (run),
        .ien     (ien),
        .flag    (flag)
    );

    cdtmr_counter #(.CNT_W(DATA_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .tick     (tick_en),
        .load     (load),
        .load_val (reg_wdata),
        .count    (count),
        .expire   (expire)
    );

    always_comb begin
        reg_rdata = '0;
        if (sel_ctrl) begin
            reg_rdata[RUN_BIT] = run;
            reg_rdata[IEN_BIT] = ien;
        end else if (sel_cnt) begin
            reg_rdata = count;
        end
    end

    assign irq = flag & ien;

    AST_STOPPED_LOAD_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel_cnt && !run) |=> $stable(count)); // R3

endmodule

// File: tb/test_cdtmr_top.sv
`timescale 1ns/1ps
module test_cdtmr_top;

    localparam logic [7:0] CTRL = 8'h40;
    localparam logic [7:0] CNT  = 8'h44;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h44;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errs   = 0;
    logic [31:0] exp_cnt;
    logic        exp_flag;

    always #10 clk = ~clk;

    cdtmr_top i_cdtmr_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq       (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = CNT;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_addr = CNT;
    endtask

    task automatic step(input logic tk);
        tick_en = tk;
        @(posedge clk);
        @(negedge clk);
        tick_en = 1'b0;
        if (tk && exp_cnt != 0) begin
            exp_cnt = exp_cnt - 1;
            if (exp_cnt == 0) exp_flag = 1'b1;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(CNT, d);  chk("R1 count", d, 0);
        rd(CTRL, d); chk("R1 ctrl", d, 0);
        chk("R1 irq", {31'd0, irq}, 0);

        // R2 map and read-back
        wr(CTRL, 32'h13);
        rd(CTRL, d); chk("R2 ctrl readback clear bit 0", d, 32'h3);
        wr(CNT, 32'd9);
        wr(8'h48, 32'd77);
        rd(8'h48, d); chk("R2 unmapped reads 0", d, 0);
        rd(CNT, d);   chk("R2 unmapped write no effect", d, 9);

        // R5/R7/R8 sweep of load values and tick patterns
        for (int n = 1; n <= 12; n++) begin
            for (int p = 0; p < 3; p++) begin
                wr(CTRL, 32'h13);
                exp_flag = 1'b0;
                wr(CNT, n);
                exp_cnt = n;
                for (int c = 0; c < 3 * n + 4; c++) begin
                    logic tk;
                    tk = (p == 0) ? 1'b1 : (p == 1) ? (c % 2 == 0) : (c % 3 != 2);
                    step(tk);
                    rd(CNT, d);
                    chk("R5 count model", d, exp_cnt);
                    chk("R8 irq model", {31'd0, irq}, {31'd0, exp_flag});
                end
                chk("R7 holds at zero", d, 0);
            end
        end

        // R9 ack together with expiry: expiry wins
        wr(CTRL, 32'h13);
        wr(CNT, 32'd1);
        reg_wr = 1'b1; reg_addr = CTRL; reg_wdata = 32'h13; tick_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = CNT; tick_en = 1'b0;
        chk("R9 expiry beats ack", {31'd0, irq}, 1);
        wr(CTRL, 32'h11);
        chk("R9 ack drops irq", {31'd0, irq}, 0);
        rd(CTRL, d); chk("R9 ack leaves ien off", d, 32'h1);

        // R6/R8 flag survives a stop write and stays hidden until enabled
        exp_flag = 1'b0;
        wr(CNT, 32'd2);
        exp_cnt = 2;
        step(1'b1);
        step(1'b1);
        chk("R8 flag masked by ien", {31'd0, irq}, 0);
        wr(CTRL, 32'h10);
        wr(CTRL, 32'h02);
        rd(CTRL, d); chk("R6 stop write ignores ien", d, 0);
        wr(CTRL, 32'h03);
        chk("R6 clear without run ignored", {31'd0, irq}, 1);

        // R3 stopped timer ignores loads and ticks
        wr(CTRL, 32'h0);
        wr(CNT, 32'd50);
        rd(CNT, d); chk("R3 load ignored", d, 0);
        wr(CTRL, 32'h01);
        wr(CNT, 32'd20);
        wr(CTRL, 32'h0);
        exp_cnt = 20;
        for (int i = 0; i < 5; i++) step(1'b1);
        rd(CNT, d); chk("R3 frozen while stopped", d, 20);
        wr(CTRL, 32'h01);
        tick_en = 1'b1; @(posedge clk); @(negedge clk); tick_en = 1'b0;
        rd(CNT, d); chk("R5 resumes", d, 19);

        // R4 reload before expiry discards old count
        wr(CTRL, 32'h13);
        wr(CNT, 32'd10);
        for (int i = 0; i < 4; i++) begin
            tick_en = 1'b1; @(posedge clk); @(negedge clk); tick_en = 1'b0;
        end
        rd(CNT, d); chk("R5 four ticks", d, 6);
        wr(CNT, 32'd7);
        rd(CNT, d); chk("R4 reload value", d, 7);
        for (int i = 0; i < 6; i++) begin
            tick_en = 1'b1; @(posedge clk); @(negedge clk); tick_en = 1'b0;
        end
        rd(CNT, d); chk("R4 count after reload", d, 1);
        chk("R4 no early irq", {31'd0, irq}, 0);
        tick_en = 1'b1; @(posedge clk); @(negedge clk); tick_en = 1'b0;
        chk("R4 irq at new expiry", {31'd0, irq}, 1);

        // R7 loading zero raises nothing
        wr(CTRL, 32'h13);
        wr(CNT, 32'd0);
        for (int i = 0; i < 3; i++) begin
            tick_en = 1'b1; @(posedge clk); @(negedge clk); tick_en = 1'b0;
        end
        chk("R7 zero load no irq", {31'd0, irq}, 0);
        rd(CNT, d); chk("R7 zero load count", d, 0);

        // R10 full width
        wr(CNT, 32'hFFFF_FFFF);
        rd(CNT, d); chk("R10 max load", d, 32'hFFFF_FFFF);
        tick_en = 1'b1; @(posedge clk); @(negedge clk); tick_en = 1'b0;
        rd(CNT, d); chk("R10 max minus one", d, 32'hFFFF_FFFE);
        @(posedge clk); @(negedge clk);
        rd(CNT, d); chk("R5 tick low holds", d, 32'hFFFF_FFFE);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

endmodule